// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block is a shared register file that sits between a host processor and a peripheral processor. Each side has its own bus with write and read enables, one 8-bit address and 32-bit write data. Each side gets a registered read result back. Four 32-bit words are held: a command word and a flag word for each direction. Either side may read any word. Writes from either side go to the same storage.

Every accepted write also emits one trace record on a single outbound stream. The record carries the register address, the written data and which side wrote it. Software on the two processors uses this for doorbell-style exchanges: write a command word, then raise a flag. A trace consumer sees every store in order. The trace stream is a valid strobe with no ready. The consumer must take a record in every cycle that `ev_valid` is high, because the block never stalls and cannot hold back a record.

When both sides write in the same cycle, the two records leave on consecutive cycles through a one-entry holding stage. Usage rule: after a cycle in which both sides write, the two sides must not both write again until a cycle with no write at all has passed. Otherwise a record would be lost.

Top module: `ipc_mailbox`

## Requirements
- R1: While `rst_n` is low and after it is released, all four words read as zero, `ev_valid` is 0 and both read-valid outputs are 0.
- R2: A write to a mapped address stores the data. The map is 0x00 host-to-peer command, 0x10 peer-to-host command, 0x20 host-to-peer flags, 0x30 peer-to-host flags. A later read of that address from either side returns the stored data.
- R3: A read with the read enable high at one clock edge gives read-valid = 1 and the data after that edge, for one cycle. While read-valid is 0, the read data is zero.
- R4: A read of any address other than the four mapped ones returns zero, with read-valid still 1.
- R5: A write to an unmapped address changes no word and produces no trace record.
- R6: After the edge that takes a mapped write, `ev_valid` is 1 for one cycle. The record fields are:
  - `ev_kind` = 0x01 (write) and `ev_subsys` = the `SUBSYS_ID` parameter (default 0x05).
  - `ev_arg0[7:0]` = address and `ev_arg1[31:0]` = data, with the upper bits zero.
  - `ev_arg2[7:0]` = side, 0 for host and 1 for peer, with the upper bits zero.
  - `ev_arg3` = 0 and `ev_flags[0]` = 0 for an undelayed record.
  - All of these outputs are zero while `ev_valid` is 0.
- R7: When both sides write the same mapped address at the same edge, the peer data is stored.
- R8: When both sides write mapped addresses at the same edge, the host record appears after that edge. The peer record follows on the next cycle with `ev_flags[0]` = 1.
- R9: A single write in the cycle after a two-side write is traced after the held peer record. It appears one cycle later, also with `ev_flags[0]` = 1.
- R10: Reads never change a word. A read at the same edge as a write to that address returns the value from before the write.
- R11: Usage rule: after a two-side write, the sides must not both write again before a cycle with no write has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_rvalid | output | 1 | Host read data valid |
| peer_wr_en | input | 1 | Peer write strobe |
| peer_rd_en | input | 1 | Peer read strobe |
| peer_addr | input | 8 | Peer register address |
| peer_wdata | input | 32 | Peer write data |
| peer_rdata | output | 32 | Peer read data, registered |
| peer_rvalid | output | 1 | Peer read data valid |
| ev_valid | output | 1 | Trace record valid (no back-pressure) |
| ev_subsys | output | 8 | Subsystem code |
| ev_kind | output | 8 | Event code, 0x01 = write |
| ev_arg0 | output | 64 | Register address |
| ev_arg1 | output | 64 | Written data |
| ev_arg2 | output | 64 | Writing side |
| ev_arg3 | output | 64 | Reserved, zero |
| ev_flags | output | 32 | Bit 0: record was delayed one or more cycles |

## Verification
A corrupted or wrongly decoded word shows at the read port exactly one cycle after the read strobe. This is why the bench sweeps every address from both sides and compares against an arithmetic model.

A fault in the holding stage shows on the trace stream two cycles after a two-side write, as a missing, duplicated or misordered record, or as a wrong delay flag. A decode fault on the write path shows one cycle after an unmapped write, as a stray record, or later as a changed word on readback.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int ADDR_W     = 8;
  localparam int NUM_SIDES  = 2;
  localparam int SIDE_W     = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1;
  localparam int SIDE_HOST  = 0;
  localparam int SIDE_PEER  = 1;
  localparam int NUM_REGS   = 4;
  localparam int REG_STRIDE = 16;
  localparam int OFF_BITS   = $clog2(REG_STRIDE);
  localparam int ARG_W      = 64;
  localparam int FLAGS_W    = 32;
  localparam int CODE_W     = 8;
  localparam logic [CODE_W-1:0] EVK_WRITE = 8'h01;

  // True when the address selects one of the stored words.
  function automatic logic addr_hits(input logic [ADDR_W-1:0] a);
    return (a[OFF_BITS-1:0] == '0) && (int'(a >> OFF_BITS) < NUM_REGS);
  endfunction

  function automatic int addr_index(input logic [ADDR_W-1:0] a);
    return int'(a >> OFF_BITS);
  endfunction
endpackage

// File: rtl/ipc_mailbox_regs.sv
module ipc_mailbox_regs
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = NUM_REGS
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_SIDES-1:0]                  wr_en,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0]      addr,
  input  logic [NUM_SIDES-1:0][DATA_W-1:0]      wdata,
  output logic [NUM_SIDES-1:0]                  hit,
  output logic [NUM_SIDES-1:0]                  wr_acc,
  output logic [NUM_SIDES-1:0][DATA_W-1:0]      rval
);
  logic [NREGS-1:0][DATA_W-1:0] word_q;

  // One storage word per register; later sides override earlier ones,
  // so the peer wins a same-word collision.
  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic              we;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] q;

    always_comb begin
      we  = 1'b0;
      nxt = q;
      for (int s = 0; s < NUM_SIDES; s++) begin
        if (wr_en[s] && addr_hits(addr[s]) && (addr_index(addr[s]) == g)) begin
          we  = 1'b1;
          nxt = wdata[s];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
    end

    assign word_q[g] = q;
  end

  // Per-side decode and read mux.
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    always_comb begin
      hit[s]    = addr_hits(addr[s]);
      wr_acc[s] = wr_en[s] && hit[s];
      rval[s]   = '0;
      for (int r = 0; r < NREGS; r++) begin
        if (hit[s] && (addr_index(addr[s]) == r)) rval[s] = word_q[r];
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox_rdport.sv
module ipc_mailbox_rdport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [DATA_W-1:0] rval,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  // One-cycle registered read; data is forced to zero when idle or unmapped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && hit) ? rval : '0;
    end
  end
endmodule

// File: rtl/ipc_mailbox_trace.sv
module ipc_mailbox_trace
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SIDES-1:0]             acc,
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_SIDES-1:0][DATA_W-1:0] wdata,
  output logic                             out_valid,
  output logic [ADDR_W-1:0]                out_addr,
  output logic [DATA_W-1:0]                out_data,
  output logic [SIDE_W-1:0]                out_side,
  output logic                             out_delayed
);
  logic              hold_v;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic [SIDE_W-1:0] hold_side;

  logic              f_v, f_del, s_v;
  logic [ADDR_W-1:0] f_addr, s_addr;
  logic [DATA_W-1:0] f_data, s_data;
  logic [SIDE_W-1:0] f_side, s_side;

  // Candidate order: held record, then sides in index order (host first).
  // First candidate goes out, second is parked in the holding stage.
  always_comb begin
    f_v = 1'b0; f_del = 1'b0; f_addr = '0; f_data = '0; f_side = '0;
    s_v = 1'b0; s_addr = '0; s_data = '0; s_side = '0;
    if (hold_v) begin
      f_v    = 1'b1;
      f_del  = 1'b1;
      f_addr = hold_addr;
      f_data = hold_data;
      f_side = hold_side;
    end
    for (int s = 0; s < NUM_SIDES; s++) begin
      if (acc[s]) begin
        if (!f_v) begin
          f_v    = 1'b1;
          f_addr = addr[s];
          f_data = wdata[s];
          f_side = SIDE_W'(s);
        end else if (!s_v) begin
          s_v    = 1'b1;
          s_addr = addr[s];
          s_data = wdata[s];
          s_side = SIDE_W'(s);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_data    <= '0;
      out_side    <= '0;
      out_delayed <= 1'b0;
      hold_v      <= 1'b0;
      hold_addr   <= '0;
      hold_data   <= '0;
      hold_side   <= '0;
    end else begin
      out_valid   <= f_v;
      out_addr    <= f_addr;
      out_data    <= f_data;
      out_side    <= f_side;
      out_delayed <= f_del;
      hold_v      <= s_v;
      hold_addr   <= s_addr;
      hold_data   <= s_data;
      hold_side   <= s_side;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter logic [7:0]       SUBSYS_ID = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [7:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              peer_wr_en,
  input  logic              peer_rd_en,
  input  logic [7:0]        peer_addr,
  input  logic [DATA_W-1:0] peer_wdata,
  output logic [DATA_W-1:0] peer_rdata,
  output logic              peer_rvalid,
  output logic              ev_valid,
  output logic [7:0]        ev_subsys,
  output logic [7:0]        ev_kind,
  output logic [63:0]       ev_arg0,
  output logic [63:0]       ev_arg1,
  output logic [63:0]       ev_arg2,
  output logic [63:0]       ev_arg3,
  output logic [31:0]       ev_flags
);
  logic [NUM_SIDES-1:0]                  wr_en_a, rd_en_a, hit_a, acc_a, rvalid_a;
  logic [NUM_SIDES-1:0][ADDR_W-1:0]      addr_a;
  logic [NUM_SIDES-1:0][DATA_W-1:0]      wdata_a, rval_a, rdata_a;

  assign wr_en_a[SIDE_HOST] = host_wr_en;
  assign wr_en_a[SIDE_PEER] = peer_wr_en;
  assign rd_en_a[SIDE_HOST] = host_rd_en;
  assign rd_en_a[SIDE_PEER] = peer_rd_en;
  assign addr_a[SIDE_HOST]  = host_addr;
  assign addr_a[SIDE_PEER]  = peer_addr;
  assign wdata_a[SIDE_HOST] = host_wdata;
  assign wdata_a[SIDE_PEER] = peer_wdata;

  ipc_mailbox_regs #(.DATA_W(DATA_W), .NREGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_a), .addr(addr_a), .wdata(wdata_a),
    .hit(hit_a), .wr_acc(acc_a), .rval(rval_a)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_rd
    ipc_mailbox_rdport #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en_a[s]), .hit(hit_a[s]), .rval(rval_a[s]),
      .rd_data(rdata_a[s]), .rd_valid(rvalid_a[s])
    );
  end

  assign host_rdata  = rdata_a[SIDE_HOST];
  assign host_rvalid = rvalid_a[SIDE_HOST];
  assign peer_rdata  = rdata_a[SIDE_PEER];
  assign peer_rvalid = rvalid_a[SIDE_PEER];

  logic              tr_valid, tr_delayed;
  logic [ADDR_W-1:0] tr_addr;
  logic [DATA_W-1:0] tr_data;
  logic [SIDE_W-1:0] tr_side;

  ipc_mailbox_trace #(.DATA_W(DATA_W)) u_trace (
    .clk(clk), .rst_n(rst_n),
    .acc(acc_a), .addr(addr_a), .wdata(wdata_a),
    .out_valid(tr_valid), .out_addr(tr_addr), .out_data(tr_data),
    .out_side(tr_side), .out_delayed(tr_delayed)
  );

  assign ev_valid  = tr_valid;
  assign ev_subsys = tr_valid ? SUBSYS_ID : '0;
  assign ev_kind   = tr_valid ? EVK_WRITE : '0;
  assign ev_arg0   = {{(ARG_W-ADDR_W){1'b0}}, tr_addr};
  assign ev_arg1   = {{(ARG_W-DATA_W){1'b0}}, tr_data};
  assign ev_arg2   = {{(ARG_W-SIDE_W){1'b0}}, tr_side};
  assign ev_arg3   = '0;
  assign ev_flags  = {{(FLAGS_W-1){1'b0}}, tr_delayed};
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_mailbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic [7:0]        host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              peer_wr_en,
  input logic              peer_rd_en,
  input logic [7:0]        peer_addr,
  input logic [DATA_W-1:0] peer_rdata,
  input logic              peer_rvalid,
  input logic              ev_valid,
  input logic [7:0]        ev_kind,
  input logic [63:0]       ev_arg2,
  input logic [63:0]       ev_arg3,
  input logic [31:0]       ev_flags
);
  logic host_acc, peer_acc, dual, any_wr, armed;
  assign host_acc = host_wr_en && addr_hits(host_addr);
  assign peer_acc = peer_wr_en && addr_hits(peer_addr);
  assign dual     = host_acc && peer_acc;
  assign any_wr   = host_acc || peer_acc;

  // Set by a two-side write, cleared by a write-free cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (dual)   armed <= 1'b1;
    else if (!any_wr) armed <= 1'b0;
  end

  // R3
  host_rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rvalid);
  // R3
  peer_rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peer_rd_en |=> peer_rvalid);
  // R3
  host_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_en |=> (!host_rvalid && host_rdata == '0));
  // R3
  peer_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !peer_rd_en |=> (!peer_rvalid && peer_rdata == '0));
  // R4
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && !addr_hits(host_addr)) |=> (host_rvalid && host_rdata == '0));
  // R6
  host_write_traced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |=> ev_valid);
  // R6
  peer_write_traced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peer_acc |=> ev_valid);
  // R6
  record_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_kind == EVK_WRITE && ev_arg3 == '0 && ev_arg2[63:1] == '0));
  // R8
  dual_second_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual |=> ##1 (ev_valid && ev_flags[0]));
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && dual));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .peer_wr_en(peer_wr_en), .peer_rd_en(peer_rd_en), .peer_addr(peer_addr),
  .peer_rdata(peer_rdata), .peer_rvalid(peer_rvalid),
  .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_arg2(ev_arg2),
  .ev_arg3(ev_arg3), .ev_flags(ev_flags)
);

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_rd_en, peer_wr_en, peer_rd_en;
  logic [7:0]  host_addr, peer_addr;
  logic [31:0] host_wdata, peer_wdata, host_rdata, peer_rdata;
  logic        host_rvalid, peer_rvalid;
  logic        ev_valid;
  logic [7:0]  ev_subsys, ev_kind;
  logic [63:0] ev_arg0, ev_arg1, ev_arg2, ev_arg3;
  logic [31:0] ev_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .peer_wr_en(peer_wr_en), .peer_rd_en(peer_rd_en), .peer_addr(peer_addr),
    .peer_wdata(peer_wdata), .peer_rdata(peer_rdata), .peer_rvalid(peer_rvalid),
    .ev_valid(ev_valid), .ev_subsys(ev_subsys), .ev_kind(ev_kind),
    .ev_arg0(ev_arg0), .ev_arg1(ev_arg1), .ev_arg2(ev_arg2), .ev_arg3(ev_arg3),
    .ev_flags(ev_flags)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus; returns at the following negedge.
  task automatic drive(input logic hw, input logic hr, input logic [7:0] ha, input logic [31:0] hd,
                       input logic pw, input logic pr, input logic [7:0] pa, input logic [31:0] pd);
    host_wr_en = hw; host_rd_en = hr; host_addr = ha; host_wdata = hd;
    peer_wr_en = pw; peer_rd_en = pr; peer_addr = pa; peer_wdata = pd;
    @(negedge clk);
    host_wr_en = 1'b0; host_rd_en = 1'b0; host_addr = '0; host_wdata = '0;
    peer_wr_en = 1'b0; peer_rd_en = 1'b0; peer_addr = '0; peer_wdata = '0;
  endtask

  task automatic idle();
    drive(0, 0, 8'h0, 32'h0, 0, 0, 8'h0, 32'h0);
  endtask

  task automatic chk_ev(input string req, input logic v, input logic [7:0] a,
                        input logic [31:0] d, input logic side, input logic del);
    check({req, " ev_valid"}, 64'(ev_valid), 64'(v));
    if (v) begin
      check({req, " kind"},   64'(ev_kind), 64'h01);
      check({req, " subsys"}, 64'(ev_subsys), 64'h05);
      check({req, " addr"},   ev_arg0, 64'(a));
      check({req, " data"},   ev_arg1, 64'(d));
      check({req, " side"},   ev_arg2, 64'(side));
      check({req, " arg3"},   ev_arg3, 64'h0);
      check({req, " flags"},  64'(ev_flags), 64'(del));
    end else begin
      check({req, " idle args"}, ev_arg0 | ev_arg1 | ev_arg2 | 64'(ev_flags) | 64'(ev_kind), 64'h0);
    end
  endtask

  task automatic rd_chk(input string req, input bit peer, input logic [7:0] a, input logic [31:0] exp);
    if (peer) drive(0, 0, 8'h0, 32'h0, 0, 1, a, 32'h0);
    else      drive(0, 1, a, 32'h0, 0, 0, 8'h0, 32'h0);
    check({req, " rvalid"}, 64'(peer ? peer_rvalid : host_rvalid), 64'h1);
    check({req, " rdata"},  64'(peer ? peer_rdata : host_rdata), 64'(exp));
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return (a[3:0] == 4'h0) && (a[7:4] < 4'd4);
  endfunction

  task automatic all_regs(input string req);
    for (int i = 0; i < 4; i++) begin
      rd_chk(req, 1'b0, 8'(i * 16), model[i]);
      rd_chk(req, 1'b1, 8'(i * 16), model[i]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    host_wr_en = 1'b0; host_rd_en = 1'b0; host_addr = '0; host_wdata = '0;
    peer_wr_en = 1'b0; peer_rd_en = 1'b0; peer_addr = '0; peer_wdata = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 reset ev_valid", 64'(ev_valid), 64'h0);
    check("R1 reset rvalid", 64'({host_rvalid, peer_rvalid}), 64'h0);
    rst_n = 1'b1;
    all_regs("R1 reset contents");

    // R2 R6: every word from every side, read back from the other side
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] d;
        d = 32'h1000_0000 * (i + 1) + 32'h0101_0101 * s + 32'hC3;
        if (s == 0) drive(1, 0, 8'(i * 16), d, 0, 0, 8'h0, 32'h0);
        else        drive(0, 0, 8'h0, 32'h0, 1, 0, 8'(i * 16), d);
        model[i] = d;
        chk_ev("R6 single write", 1'b1, 8'(i * 16), d, 1'(s), 1'b0);
        rd_chk("R2 cross read", (s == 0), 8'(i * 16), d);
        chk_ev("R6 one-cycle pulse", 1'b0, 8'h0, 32'h0, 1'b0, 1'b0);
        idle();
        // R3: read-valid and data drop after the read cycle
        check("R3 rvalid low", 64'({host_rvalid, peer_rvalid}), 64'h0);
        check("R3 rdata zero", 64'(host_rdata | peer_rdata), 64'h0);
      end
    end

    // R4 R5: sweep the whole address space
    for (int a = 0; a < 256; a++) begin
      if (!mapped(8'(a))) begin
        drive(1, 0, 8'(a), ~32'(a), 0, 0, 8'h0, 32'h0);
        check("R5 no record for unmapped write", 64'(ev_valid), 64'h0);
        rd_chk("R4 unmapped read", 1'b1, 8'(a), 32'h0);
      end else begin
        rd_chk("R2 mapped sweep", 1'b1, 8'(a), model[a / 16]);
      end
    end
    all_regs("R5 words unchanged");

    // R7 R8: both sides write the same word
    drive(1, 0, 8'h20, 32'hAAAA_0001, 1, 0, 8'h20, 32'h5555_0002);
    model[2] = 32'h5555_0002;
    chk_ev("R8 host first", 1'b1, 8'h20, 32'hAAAA_0001, 1'b0, 1'b0);
    idle();
    chk_ev("R8 peer second", 1'b1, 8'h20, 32'h5555_0002, 1'b1, 1'b1);
    idle();
    chk_ev("R8 no third", 1'b0, 8'h0, 32'h0, 1'b0, 1'b0);
    rd_chk("R7 peer wins", 1'b0, 8'h20, 32'h5555_0002);

    // R8: both sides, different words
    drive(1, 0, 8'h00, 32'hE000_0001, 1, 0, 8'h30, 32'hE000_0002);
    model[0] = 32'hE000_0001; model[3] = 32'hE000_0002;
    chk_ev("R8 host first diff", 1'b1, 8'h00, 32'hE000_0001, 1'b0, 1'b0);
    idle();
    chk_ev("R8 peer second diff", 1'b1, 8'h30, 32'hE000_0002, 1'b1, 1'b1);
    idle();
    all_regs("R8 both stored");

    // R9: dual write followed by a single write
    drive(1, 0, 8'h10, 32'hF000_0001, 1, 0, 8'h20, 32'hF000_0002);
    chk_ev("R9 host first", 1'b1, 8'h10, 32'hF000_0001, 1'b0, 1'b0);
    drive(1, 0, 8'h30, 32'hF000_0003, 0, 0, 8'h0, 32'h0);
    chk_ev("R9 held peer", 1'b1, 8'h20, 32'hF000_0002, 1'b1, 1'b1);
    idle();
    chk_ev("R9 delayed single", 1'b1, 8'h30, 32'hF000_0003, 1'b0, 1'b1);
    idle();
    chk_ev("R9 drained", 1'b0, 8'h0, 32'h0, 1'b0, 1'b0);
    model[1] = 32'hF000_0001; model[2] = 32'hF000_0002; model[3] = 32'hF000_0003;
    all_regs("R9 contents");

    // R10: read at the write edge returns the old value
    drive(1, 1, 8'h00, 32'h0BAD_F00D, 0, 1, 8'h00, 32'h0);
    check("R10 host old value", 64'(host_rdata), 64'(model[0]));
    check("R10 peer old value", 64'(peer_rdata), 64'(model[0]));
    model[0] = 32'h0BAD_F00D;
    all_regs("R10 reads leave words intact");
    all_regs("R10 repeated reads");

    // R1: reset clears stored words mid-run
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) model[i] = '0;
    all_regs("R1 cleared by reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule